// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer Bank

This block holds five independent timer channels behind a small register port. Every channel owns a 32-bit counter that counts downward by one on each cycle where its own tick-enable input is high. The tick inputs stand in for a prescaler that lives outside the block. When a counter that already holds zero receives another tick, the channel expires. It raises a one-cycle pulse on its interrupt line. It then either reloads from its count buffer and keeps going, or stops and clears its own start bit.

Software never writes a counter directly. It writes a count buffer, and for channels 0 to 3 also a compare buffer. It then sets the channel's manual-update bit in the shared control word, which copies the buffers into the active counter. A second control write clears manual update and sets start. A count buffer value V gives a period of V + 1 ticks. A channel loaded with all ones in periodic mode is a free-running down counter whose bitwise inverse serves as a rising, wrapping timestamp.

The register port is synchronous. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the read request and holds until the next read.

Top module: `dcnt_bank`

## Requirements
- R1: Each of the five 32-bit counters decrements by one at a clock edge only when its tick input is high, its start bit is set and its manual-update bit is clear. With no tick, the counter holds.
- R2: The control word at offset 0x08 has one field per channel, with its least significant bit at bit 0 for channel 0, bit 8 for channel 1, bit 12 for channel 2, bit 16 for channel 3 and bit 20 for channel 4. In channels 0 to 3, field bit 0 is start, bit 1 is manual update, bit 2 is an invert flag that is stored only, and bit 3 is auto-reload. Channel 4 has three bits: start, manual update and auto-reload. All other bits read back as zero, so after reset the word reads 0.
- R3: Clearing a channel's start bit freezes its counter at its current value, even while ticks arrive. The channel's buffers keep their contents.
- R4: While manual update is set, the counter takes its count buffer's value on every cycle and does not count down, even with start set and ticks arriving. With manual update clear, a write to the count buffer leaves the running counter unchanged.
- R5: After loading value V and starting, the interrupt fires on the (V+1)-th tick. The counter reads 0 after V ticks.
- R6: With auto-reload set, expiry loads the count buffer into the counter, and the channel repeats every V+1 ticks.
- R7: With auto-reload clear, expiry leaves the counter at 0 and clears the channel's start bit in the control word. No later tick produces another interrupt.
- R8: irq[n] belongs to channel n. It is high for exactly the one cycle after the clock edge on which that channel expired.
- R9: For n from 0 to 3, the count buffer sits at 0x0C+0x0C*n, the compare buffer at 0x10+0x0C*n and the read-only counter view at 0x14+0x0C*n. Channel 4 has its count buffer at 0x3C and its counter view at 0x40. Buffers read back as written, and reads of any other offset return 0.
- R10: A channel set to all ones with auto-reload runs freely. It wraps from 0 back to 0xFFFFFFFF, so its inverse climbs and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | High for write, low for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tick_en | input | 5 | Per-channel count enable |
| irq | output | 5 | Per-channel expiry pulse |

## Verification
The bench aims at the exact tick on which expiry occurs. A design that treats V as the period, not V+1, fires one tick early, and a two-cycle or late pulse shows up at the cycles sampled either side of it. It checks that manual update really holds the counter while ticks arrive, and that a buffer write while the channel runs leaves the counter alone. A design that loaded on a buffer write would read back the wrong counter value. It checks that a one-shot channel clears its own start bit and stays silent afterwards, that channel 4's narrow field puts auto-reload at bit 22, and that the free-running channel wraps to all ones. A design with a shifted field or a missing mask would read back stray control bits or fail to reload.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    localparam int NUM_CH = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int CTRL_W = 23;

    localparam logic [ADDR_W-1:0] CTRL_OFF  = 8'h08;
    // bits 7:4 are a hole between channel 0 and channel 1
    localparam logic [CTRL_W-1:0] CTRL_MASK = 23'h7F_FF0F;

    localparam int START_B       = 0;
    localparam int MANUAL_B      = 1;
    localparam int RELOAD_B      = 3;
    localparam int RELOAD_B_LAST = 2;

    function automatic int fld_lsb(input int n);
        return (n == 0) ? 0 : 4 * n + 4;
    endfunction

    function automatic int reload_pos(input int n);
        return (n == NUM_CH - 1) ? RELOAD_B_LAST : RELOAD_B;
    endfunction

    function automatic logic [ADDR_W-1:0] cbuf_off(input int n);
        return (n < NUM_CH - 1) ? ADDR_W'(12 + 12 * n) : 8'h3C;
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_off(input int n);
        return ADDR_W'(16 + 12 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] obs_off(input int n);
        return (n < NUM_CH - 1) ? ADDR_W'(20 + 12 * n) : 8'h40;
    endfunction
endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
    import dcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] stop_req,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] manual_o,
    output logic [NUM_CH-1:0] reload_o,
    output logic [CTRL_W-1:0] word_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data & CTRL_MASK;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (stop_req[n]) begin
                    st_d.word[fld_lsb(n) + START_B] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_fld
        localparam int L = fld_lsb(n);
        assign start_o[n]  = st_q.word[L + START_B];
        assign manual_o[n] = st_q.word[L + MANUAL_B];
        assign reload_o[n] = st_q.word[L + reload_pos(n)];

        AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_req[n] && !wr_en) |=> !start_o[n]); // R7
        AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (start_o[n] == $past(wr_data[L + START_B]))); // R2
    end
endmodule

// File: rtl/dcnt_chan.sv
module dcnt_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             manual,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             stop_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        active;
    logic        expire;

    assign active     = !manual && start && tick;
    assign expire     = active && (st_q.cnt == '0);
    assign stop_req_o = expire && !reload;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (manual) begin
            st_d.cnt = load_val;
        end else if (active) begin
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                if (reload) st_d.cnt = load_val;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign irq_o   = st_q.irq;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !manual && tick && count_o != '0) |=> (count_o == $past(count_o) - 1'b1)); // R1
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !manual) |=> $stable(count_o)); // R3
    AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> (count_o == $past(load_val))); // R4
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !manual && tick && reload && count_o == '0) |=> (count_o == $past(load_val))); // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(count_o) == '0 && $past(tick) && $past(start))); // R8
endmodule

// File: rtl/dcnt_bank.sv
module dcnt_bank
    import dcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] irq
);
    localparam int NUM_CMP = NUM_CH - 1;

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf;
        logic [NUM_CMP-1:0][CNT_W-1:0] cmp_buf;
        logic [DATA_W-1:0]             rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic                         wr, rd;
    logic                         ctrl_wr;
    logic [NUM_CH-1:0]            start, manual, reload, stop_req;
    logic [CTRL_W-1:0]            ctrl_word;
    logic [NUM_CH-1:0][CNT_W-1:0] count;
    logic [DATA_W-1:0]            rd_val;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign ctrl_wr = wr && (bus_addr == CTRL_OFF);

    always_comb begin
        rd_val = '0;
        if (bus_addr == CTRL_OFF) rd_val = DATA_W'(ctrl_word);
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == cbuf_off(n)) rd_val = DATA_W'(st_q.cnt_buf[n]);
            if (bus_addr == obs_off(n))  rd_val = DATA_W'(count[n]);
        end
        for (int n = 0; n < NUM_CMP; n++) begin
            if (bus_addr == cmp_off(n)) rd_val = DATA_W'(st_q.cmp_buf[n]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_addr == cbuf_off(n)) st_d.cnt_buf[n] = bus_wdata[CNT_W-1:0];
            end
            for (int n = 0; n < NUM_CMP; n++) begin
                if (bus_addr == cmp_off(n)) st_d.cmp_buf[n] = bus_wdata[CNT_W-1:0];
            end
        end
        if (rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    dcnt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_data  (bus_wdata[CTRL_W-1:0]),
        .stop_req (stop_req),
        .start_o  (start),
        .manual_o (manual),
        .reload_o (reload),
        .word_o   (ctrl_word)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        dcnt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start[n]),
            .manual     (manual[n]),
            .reload     (reload[n]),
            .tick       (tick_en[n]),
            .load_val   (st_q.cnt_buf[n]),
            .count_o    (count[n]),
            .irq_o      (irq[n]),
            .stop_req_o (stop_req[n])
        );
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == 8'h00) |=> (bus_rdata == '0)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/dcnt_bank_test.sv
`timescale 1ns/1ps
module dcnt_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [7:0]  addr;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;

    dcnt_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq)
    );

    always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_we;

    // monitor: read data is valid after the edge that sampled the request
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_item_t it;
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run_ticks(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            tick_en[ch] = 1'b1;
            @(negedge clk);
        end
        tick_en[ch] = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R8 reset irq", {27'b0, irq}, 32'h0);
        rd(8'h08, 32'h0, "R2 reset control");
        rd(8'h14, 32'h0, "R9 reset counter view");

        // R2: unused control bits read zero, channel 4 field is three bits
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h007F_FF0F, "R2 field mask");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h0, "R2 cleared");

        // channel 1 periodic, V=3
        wr(8'h18, 32'd3);
        wr(8'h08, 32'h0000_0A00);            // manual + reload
        tick_en[1] = 1'b1;
        wr(8'h08, 32'h0000_0B00);            // start while manual still set
        tick_en[1] = 1'b0;
        rd(8'h20, 32'd3, "R4 manual holds counter");
        wr(8'h08, 32'h0000_0900);            // start + reload
        rd(8'h20, 32'd3, "R4 counting not begun without tick");
        run_ticks(1, 3);
        chk("R5 no early irq", {27'b0, irq}, 32'h0);
        rd(8'h20, 32'd0, "R5 counter at zero after V ticks");
        run_ticks(1, 1);
        chk("R5 irq on tick V+1", {27'b0, irq}, 32'h2);
        rd(8'h20, 32'd3, "R6 reloaded");
        chk("R8 pulse one cycle", {27'b0, irq}, 32'h0);
        run_ticks(1, 3);
        chk("R6 no irq mid period", {27'b0, irq}, 32'h0);
        run_ticks(1, 1);
        chk("R6 second period irq", {27'b0, irq}, 32'h2);
        wr(8'h08, 32'h0);

        // channel 0 one-shot, V=1
        wr(8'h0C, 32'd1);
        wr(8'h10, 32'hABCD_0123);
        wr(8'h08, 32'h0000_0006);            // manual + invert
        wr(8'h08, 32'h0000_0005);            // start + invert
        run_ticks(0, 1);
        chk("R5 one-shot no early irq", {27'b0, irq}, 32'h0);
        run_ticks(0, 1);
        chk("R7 one-shot irq", {27'b0, irq}, 32'h1);
        rd(8'h08, 32'h0000_0004, "R7 start bit cleared");
        rd(8'h14, 32'd0, "R7 counter stays zero");
        for (int i = 0; i < 3; i++) begin
            run_ticks(0, 1);
            chk("R7 silent after expiry", {27'b0, irq}, 32'h0);
        end
        rd(8'h10, 32'hABCD_0123, "R9 compare buffer");
        rd(8'h0C, 32'd1, "R9 count buffer");

        // channel 2 halt
        wr(8'h24, 32'd10);
        wr(8'h08, 32'h0000_2000);
        wr(8'h08, 32'h0000_1000);
        repeat (3) @(negedge clk);
        rd(8'h2C, 32'd10, "R1 holds without tick");
        run_ticks(3, 2);                     // other channel's tick
        rd(8'h2C, 32'd10, "R1 other tick ignored");
        run_ticks(2, 2);
        rd(8'h2C, 32'd8, "R1 decrement");
        wr(8'h08, 32'h0);
        run_ticks(2, 5);
        rd(8'h2C, 32'd8, "R3 halted");
        rd(8'h24, 32'd10, "R3 buffer kept");

        // channel 4 free-running wrap
        wr(8'h3C, 32'd5);
        wr(8'h08, 32'h0060_0000);            // manual + reload (bit 22)
        wr(8'h08, 32'h0050_0000);            // start + reload
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h40, 32'd5, "R4 buffer write leaves counter");
        run_ticks(4, 6);
        chk("R8 irq on channel 4 only", {27'b0, irq}, 32'h10);
        rd(8'h40, 32'hFFFF_FFFF, "R10 wrap to all ones, inverse 0");
        run_ticks(4, 2);
        rd(8'h40, ~32'd2, "R10 inverse climbs to 2");
        rd(8'h3C, 32'hFFFF_FFFF, "R9 channel 4 count buffer");

        // unmapped offsets
        rd(8'h00, 32'h0, "R9 unmapped 0x00");
        rd(8'h44, 32'h0, "R9 unmapped 0x44");
        rd(8'h04, 32'h0, "R9 unmapped 0x04");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule